// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous start-stop bit stream on a single line. Characters arrive over a valid/ready handshake; each is framed with one low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a high stop period. All bit timing is counted in pulses of an external enable (`tick16`) running at sixteen times the bit rate. The stop period is set in sixteenths of a bit, so fractional lengths between one and two bits are possible.

Besides data, the block can send two line-conditioning characters on request. A preamble holds the line high, and a break holds it low. Each lasts exactly the time of one full character in the current format. A `freeze` input pauses the stream. The character on the line finishes, and nothing new starts until `freeze` drops. Line format (length, parity, stop length) is captured when a character is accepted, so changing it mid-frame does not affect that frame.

The controller is a single state machine:
- `ST_IDLE`: line high. It goes to `ST_BREAK`, `ST_PREAMBLE` or `ST_START`, in that priority, when not frozen.
- `ST_START` → `ST_DATA`: after 16 ticks.
- `ST_DATA`: stays in this state for each data bit. After the last bit it goes to `ST_PARITY` when parity is enabled, otherwise to `ST_STOP`.
- `ST_PARITY` → `ST_STOP`: after 16 ticks.
- `ST_STOP` → `ST_IDLE`: after the programmed stop length.
- `ST_PREAMBLE` / `ST_BREAK` → `ST_IDLE`: after one character time.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, and whenever no character or request is in progress, `txd` is 1 and `busy` is 0. `in_ready` is 1 when idle and not frozen with no request pending.
- R2: An accepted character starts on the next clock with `txd` low for 16 ticks. Each data bit then follows, least significant first, and each lasts 16 ticks.
- R3: `cfg_len` sets the number of data bits: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Higher input bits are not sent.
- R4: `cfg_parity` selects the parity bit, which lasts 16 ticks after the data. The codes are: 0 for no parity bit, 1 for even (data plus parity has an even count of ones), 2 for odd, and 3 for a bit equal to `cfg_force_par`.
- R5: The stop period is high for `cfg_stop` ticks. Values below 16 act as 16, and values above 32 act as 32.
- R6: A one-cycle `preamble_req` while idle holds `txd` high with `busy` 1 for one character time. One character time is 16×(1+data bits+parity bits) + stop ticks.
- R7: A one-cycle `break_req` while idle holds `txd` low with `busy` 1 for one character time.
- R8: While idle, `break_req` wins over `preamble_req`, which wins over `in_valid`. `in_ready` is 0 while either request is high.
- R9: Raising `freeze` lets the current character finish unchanged. While it is high, no new character or request starts, `txd` stays 1 and `in_ready` is 0. After release, a pending character is accepted.
- R10: While busy, `txd` changes only on clock edges where `tick16` is high.
- R11: `in_ready` is 0 while a character or request is in progress or while frozen. A character is accepted only on a cycle with both `in_valid` and `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversample enable, 16 per bit |
| cfg_len | input | 2 | Data length select (5 + value bits) |
| cfg_parity | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 forced |
| cfg_force_par | input | 1 | Value sent in forced parity mode |
| cfg_stop | input | STOP_W (6) | Stop length in ticks, clamped to 16..32 |
| in_valid | input | 1 | Character available |
| in_data | input | DW (8) | Character to send |
| in_ready | output | 1 | Character is accepted this cycle when valid |
| preamble_req | input | 1 | Request one high idle character |
| break_req | input | 1 | Request one low break character |
| freeze | input | 1 | Pause after the current character |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A character or request is in progress |

## Verification
All sixteen combinations of data length and parity mode are swept across four stop lengths, with varied data. This separates bit-count, parity-polarity and stop-timing faults. An exhaustive pass over every 5-bit value, alternating odd and forced parity, shows the parity logic covers exactly the sent bits. Two out-of-range stop values probe both clamp ends. A simultaneous break, preamble and data request shows the priority order. A freeze raised mid-frame, then held with a character waiting, shows that the frame completes, that nothing starts during the freeze, and that the character is accepted after release.

// File: rtl/utx_pkg.sv
`timescale 1ns/1ps
package utx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_FORCE = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_PREAMBLE,
        ST_BREAK
    } tx_state_e;

endpackage

// File: rtl/utx_parity.sv
`timescale 1ns/1ps
module utx_parity #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic [1:0]    len_sel,
    input  logic [1:0]    mode,
    input  logic          force_val,
    output logic          par_bit
);
    import utx_pkg::*;

    logic ones_odd;

    // XOR over only the bits that will be sent
    always_comb begin
        ones_odd = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < 5 + int'(len_sel)) begin
                ones_odd = ones_odd ^ data[i];
            end
        end
    end

    always_comb begin
        unique case (par_mode_e'(mode))
            PAR_EVEN:  par_bit = ones_odd;
            PAR_ODD:   par_bit = ~ones_odd;
            PAR_FORCE: par_bit = force_val;
            default:   par_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/utx_tick_timer.sv
`timescale 1ns/1ps
module utx_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // the element ends on the tick that consumes its last count
    assign expire = tick && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/uart_tx_core.sv
`timescale 1ns/1ps
module uart_tx_core #(
    parameter int OVS    = 16,
    parameter int DW     = 8,
    parameter int STOP_W = $clog2(2*OVS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_force_par,
    input  logic [STOP_W-1:0] cfg_stop,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_data,
    output logic              in_ready,
    input  logic              preamble_req,
    input  logic              break_req,
    input  logic              freeze,
    output logic              txd,
    output logic              busy
);
    import utx_pkg::*;

    localparam int CNT_W = $clog2(OVS*(DW + 2) + 2*OVS + 1);
    localparam int IDX_W = $clog2(DW);

    tx_state_e          state_q, state_d;
    logic [DW-1:0]      shreg_q;
    logic [IDX_W-1:0]   bitidx_q;
    logic [1:0]         len_q;
    logic               has_par_q;
    logic               par_bit_q;
    logic [CNT_W-1:0]   stop_q;

    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_done;
    logic [CNT_W-1:0]   stop_clamped;
    logic [CNT_W-1:0]   char_ticks;
    logic               par_calc;
    logic               last_bit;
    logic               accept;

    utx_parity #(.DW(DW)) u_parity (
        .data      (in_data),
        .len_sel   (cfg_len),
        .mode      (cfg_parity),
        .force_val (cfg_force_par),
        .par_bit   (par_calc)
    );

    utx_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_done)
    );

    // stop length limited to one..two bit times
    always_comb begin
        if (cfg_stop < STOP_W'(OVS)) begin
            stop_clamped = CNT_W'(OVS);
        end else if (cfg_stop > STOP_W'(2*OVS)) begin
            stop_clamped = CNT_W'(2*OVS);
        end else begin
            stop_clamped = CNT_W'(cfg_stop);
        end
    end

    // duration of a whole character in the present format
    always_comb begin
        char_ticks = CNT_W'(OVS * (6 + int'(cfg_len) + ((cfg_parity != 2'd0) ? 1 : 0)))
                   + stop_clamped;
    end

    assign last_bit = (bitidx_q == IDX_W'(int'(len_q) + 4));
    assign accept   = (state_q == ST_IDLE) && (state_d == ST_START);

    // next state and element timing
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(OVS);
        unique case (state_q)
            ST_IDLE: begin
                if (!freeze) begin
                    if (break_req) begin
                        state_d  = ST_BREAK;
                        tmr_load = 1'b1;
                        tmr_val  = char_ticks;
                    end else if (preamble_req) begin
                        state_d  = ST_PREAMBLE;
                        tmr_load = 1'b1;
                        tmr_val  = char_ticks;
                    end else if (in_valid) begin
                        state_d  = ST_START;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_START: begin
                if (tmr_done) begin
                    state_d  = ST_DATA;
                    tmr_load = 1'b1;
                end
            end
            ST_DATA: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (last_bit) begin
                        if (has_par_q) begin
                            state_d = ST_PARITY;
                        end else begin
                            state_d = ST_STOP;
                            tmr_val = stop_q;
                        end
                    end
                end
            end
            ST_PARITY: begin
                if (tmr_done) begin
                    state_d  = ST_STOP;
                    tmr_load = 1'b1;
                    tmr_val  = stop_q;
                end
            end
            ST_STOP, ST_PREAMBLE, ST_BREAK: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // character capture and shifting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bitidx_q  <= '0;
            len_q     <= '0;
            has_par_q <= 1'b0;
            par_bit_q <= 1'b0;
            stop_q    <= CNT_W'(OVS);
        end else if (accept) begin
            shreg_q   <= in_data;
            bitidx_q  <= '0;
            len_q     <= cfg_len;
            has_par_q <= (cfg_parity != 2'd0);
            par_bit_q <= par_calc;
            stop_q    <= stop_clamped;
        end else if (state_q == ST_DATA && tmr_done) begin
            shreg_q  <= shreg_q >> 1;
            bitidx_q <= bitidx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        in_ready = (state_q == ST_IDLE) && !freeze && !break_req && !preamble_req;
        unique case (state_q)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg_q[0];
            ST_PARITY: txd = par_bit_q;
            ST_BREAK:  txd = 1'b0;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/utx_tx_chk.sv
`timescale 1ns/1ps
module utx_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic freeze,
    input logic in_valid,
    input logic in_ready,
    input logic preamble_req,
    input logic break_req,
    input logic txd,
    input logic busy
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> busy && !txd);

    // R6
    preamble_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preamble_req && !break_req && !busy && !freeze |=> busy && txd);

    // R7
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        break_req && !busy && !freeze |=> busy && !txd);

    // R8
    request_blocks_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (break_req || preamble_req) |-> !in_ready);

    // R9
    freeze_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && !busy |=> !busy);

    // R10
    txd_tick_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !tick16 |=> $stable(txd));

    // R11
    ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !busy && !freeze);

endmodule

bind uart_tx_core utx_tx_chk u_chk (.*);

// File: tb/uart_tx_core_test.sv
`timescale 1ns/1ps
module uart_tx_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_parity = 2'd0;
    logic       cfg_force_par = 1'b0;
    logic [5:0] cfg_stop = 6'd16;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       preamble_req = 1'b0;
    logic       break_req = 1'b0;
    logic       freeze = 1'b0;
    logic       txd;
    logic       busy;

    int checks = 0;
    int errors = 0;
    logic exp_w [0:255];
    int n_exp = 0;

    always #2.5 clk = ~clk;

    uart_tx_core uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick16        (tick16),
        .cfg_len       (cfg_len),
        .cfg_parity    (cfg_parity),
        .cfg_force_par (cfg_force_par),
        .cfg_stop      (cfg_stop),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_ready      (in_ready),
        .preamble_req  (preamble_req),
        .break_req     (break_req),
        .freeze        (freeze),
        .txd           (txd),
        .busy          (busy)
    );

    // oversample enable: every other clock
    initial begin
        forever begin
            @(negedge clk);
            tick16 = tick_en ? ~tick16 : 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int stop_ticks(input int s);
        if (s < 16) return 16;
        if (s > 32) return 32;
        return s;
    endfunction

    function automatic int char_ticks(input int len, input int par, input int s);
        return 16 * (6 + len + (par != 0 ? 1 : 0)) + stop_ticks(s);
    endfunction

    task automatic build_frame(input logic [7:0] d, input int len, input int par,
                               input logic fv, input int s);
        int nb = 5 + len;
        logic ones = 1'b0;
        logic pb;
        n_exp = 0;
        for (int i = 0; i < 16; i++) begin exp_w[n_exp] = 1'b0; n_exp++; end
        for (int b = 0; b < nb; b++) begin
            ones = ones ^ d[b];
            for (int i = 0; i < 16; i++) begin exp_w[n_exp] = d[b]; n_exp++; end
        end
        if (par != 0) begin
            pb = (par == 1) ? ones : (par == 2) ? ~ones : fv;
            for (int i = 0; i < 16; i++) begin exp_w[n_exp] = pb; n_exp++; end
        end
        for (int i = 0; i < stop_ticks(s); i++) begin exp_w[n_exp] = 1'b1; n_exp++; end
    endtask

    task automatic build_level(input logic lvl, input int n);
        n_exp = n;
        for (int i = 0; i < n; i++) exp_w[i] = lvl;
    endtask

    // compares txd (and busy) on every cycle against the element of the coming tick
    task automatic collect(input string req);
        int cnt = 0;
        int bad = 0;
        int act = 0;
        int expv = 0;
        while (cnt < n_exp) begin
            #1;
            if (txd !== exp_w[cnt] || busy !== 1'b1) begin
                if (bad == 0) begin act = int'(txd); expv = int'(exp_w[cnt]); end
                bad++;
            end
            if (tick16) cnt++;
            if (cnt < n_exp) @(negedge clk);
        end
        chk(bad == 0, req, $sformatf("line waveform (%0d bad samples) txd", bad), act, expv);
    endtask

    task automatic accept(input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        #1;
        chk(in_ready == 1'b1, "R11", "in_ready when idle", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_idle(input string req);
        @(negedge clk);
        #1;
        chk(busy == 1'b0 && txd == 1'b1, req, "idle busy/txd", {busy, txd}, 1);
    endtask

    task automatic run_frame(input logic [7:0] d, input int len, input int par,
                             input logic fv, input int s, input string req);
        cfg_len = 2'(len);
        cfg_parity = 2'(par);
        cfg_force_par = fv;
        cfg_stop = 6'(s);
        build_frame(d, len, par, fv, s);
        accept(d);
        collect(req);
        check_idle("R1");
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int stops [4] = '{16, 20, 27, 32};
        int bad;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        tick_en = 1'b1;
        #1;
        // R1 reset state
        chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        // R2 R3 R4 R5: length x parity x stop sweep
        for (int len = 0; len < 4; len++)
            for (int par = 0; par < 4; par++)
                for (int si = 0; si < 4; si++)
                    run_frame(8'(len * 61 + par * 17 + si * 5 + 8'h5A), len, par,
                              1'((len + si) % 2), stops[si], "R2 R3 R4 R5 R10");

        // R5 clamp at both ends
        run_frame(8'hC3, 3, 1, 1'b0, 3, "R5 low clamp");
        run_frame(8'h3C, 2, 0, 1'b0, 45, "R5 high clamp");

        // R3 R4 exhaustive 5-bit data, odd and forced parity
        for (int d = 0; d < 32; d++)
            run_frame(8'(d) | 8'hE0, 0, (d % 2 == 0) ? 2 : 3, 1'(d >> 1), 16, "R3 R4 exhaustive");

        // R8 R7: all three requests together, break wins
        cfg_len = 2'd3; cfg_parity = 2'd1; cfg_stop = 6'd16;
        @(negedge clk);
        break_req = 1'b1; preamble_req = 1'b1; in_valid = 1'b1; in_data = 8'hFF;
        #1;
        chk(in_ready == 1'b0, "R8", "in_ready with requests", int'(in_ready), 0);
        @(negedge clk);
        break_req = 1'b0; preamble_req = 1'b0; in_valid = 1'b0;
        build_level(1'b0, char_ticks(3, 1, 16));
        collect("R7 R8 break");
        check_idle("R7");

        // R6 R8: preamble beats data
        cfg_len = 2'd0; cfg_parity = 2'd0; cfg_stop = 6'd24;
        @(negedge clk);
        preamble_req = 1'b1; in_valid = 1'b1; in_data = 8'h00;
        #1;
        chk(in_ready == 1'b0, "R8", "in_ready with preamble", int'(in_ready), 0);
        @(negedge clk);
        preamble_req = 1'b0; in_valid = 1'b0;
        build_level(1'b1, char_ticks(0, 0, 24));
        collect("R6 R8 preamble");
        check_idle("R6");

        // R9: freeze mid-frame, hold with a character waiting, then release
        cfg_len = 2'd3; cfg_parity = 2'd0; cfg_stop = 6'd16;
        build_frame(8'h3C, 3, 0, 1'b0, 16);
        accept(8'h3C);
        freeze = 1'b1;
        collect("R9 frame completes under freeze");
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h81;
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            #1;
            if (in_ready || busy || !txd) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R9", "activity while frozen", bad, 0);
        freeze = 1'b0;
        build_frame(8'h81, 3, 0, 1'b0, 16);
        @(negedge clk);
        in_valid = 1'b0;
        collect("R9 R11 frame after release");
        check_idle("R9");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule